// File: doc/BRIEF.md
# Windowed Watchdog Timer Core

This block supervises software liveness through a small synchronous register port. Once enabled, it counts base ticks from an internal prescaler and expects periodic feed writes. It runs in one of two modes. In slow mode only a late deadline is enforced. In window mode a feed that comes too soon is also treated as a fault. The early limit is a power-of-two number of base ticks. The late limit is 2, 4, 8 or 16 times that early limit, selected by a ratio code.

On a fault the block emits a one-cycle pulse on the interrupt output. When the action bit selects it, the block also pulses the reset output. The tick count then restarts from zero. Disabling the block, rewriting either configuration register, or feeding it also restarts the count. The prescaler terminal count is a parameter: 55000 clocks gives 1.1 ms at 50 MHz, and a test setup can shorten it.

Top module: `wwdt_core`

## Requirements
- R1: After reset, both outputs are low and the control register (address 0) and timing register (address 1) read 0, which means the block is disabled.
- R2: The control register at address 0 holds the run code in bits 1:0, the mode bit in bit 2 (1 = slow, 0 = window) and the action bit in bit 3. The timing register at address 1 holds the short-limit select in bits 6:4 and the ratio code in bits 1:0. Bits without a field read 0.
- R3: Writing a 1 to bit 0 of address 2 is a feed. Address 2 always reads 0.
- R4: One base tick is CLK_PER_TICK clocks. The short limit is 2^select ticks. A feed is early when it is sampled at most short×CLK_PER_TICK clock edges after the last restart.
- R5: The long limit is short × 2^(ratio+1) ticks. If no feed arrives, the fault pulse appears exactly long×CLK_PER_TICK clock edges after the last restart.
- R6: In window mode, an early feed faults on the edge where it is sampled. A later feed is accepted and restarts the count.
- R7: In slow mode, no feed ever faults. Every feed restarts the count.
- R8: Each fault pulses the interrupt output for one cycle. When the action bit is 1, the reset output pulses in the same cycle. When the action bit is 0, the reset output stays low.
- R9: Only run code 01 counts. Codes 00, 10 and 11 hold the count at zero and raise no fault, and leaving run code 01 discards the elapsed time.
- R10: After a fault the count restarts from zero, so an unfed block faults again one long limit later.
- R11: Any write to address 0 or address 1 restarts the count.
- R12: A valid feed sampled on the same edge as the long-limit expiry cancels the timeout and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| wdog_rst_o | output | 1 | One-cycle reset request on a fault |
| wdog_irq_o | output | 1 | One-cycle interrupt on every fault |

## Verification
The collision of interest is a feed arriving on the very edge where the last tick of the long limit expires. There, the feed-accept path and the timeout path both try to act. The bench provokes it by timing a feed to land exactly long×CLK_PER_TICK edges after a restart. It then expects no pulse on that edge and a fresh timeout one full long limit later. The boundary on the early side is provoked the same way: a feed exactly short×CLK_PER_TICK edges after a restart must fault, and one edge later it must not.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

  localparam int CNT_W = 12;  // holds up to 128 << 4 = 2048 ticks

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TIME = 2'd1;
  localparam logic [1:0] ADDR_FEED = 2'd2;

  typedef enum logic [1:0] {
    RUN_OFF  = 2'b00,
    RUN_ON   = 2'b01,
    RUN_QA   = 2'b10,
    RUN_RSVD = 2'b11
  } run_code_e;

  // bit 3: action, bit 2: slow mode, bits 1:0: run code
  typedef struct packed {
    logic      act_rst;
    logic      slow;
    run_code_e run;
  } ctrl_t;

  typedef struct packed {
    logic [2:0] sel;
    logic [1:0] ratio;
  } timing_t;

  function automatic logic [CNT_W-1:0] short_ticks(input logic [2:0] sel);
    return CNT_W'(1) << sel;
  endfunction

  function automatic logic [CNT_W-1:0] long_ticks(input logic [2:0] sel,
                                                  input logic [1:0] ratio);
    return short_ticks(sel) << ({1'b0, ratio} + 3'd1);
  endfunction

endpackage

// File: rtl/wwdt_prescaler.sv
module wwdt_prescaler #(
  parameter int DIV = 55000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = run;
    end else begin : g_count
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (!run || clear || cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick = run && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wwdt_regs.sv
module wwdt_regs
  import wwdt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output ctrl_t         ctrl_o,
  output timing_t       timing_o,
  output logic          ctrl_wr_o,
  output logic          timing_wr_o,
  output logic          feed_o
);
  ctrl_t   ctrl_q;
  timing_t timing_q;
  logic    unused_wdata;

  assign ctrl_wr_o   = we && (addr == ADDR_CTRL);
  assign timing_wr_o = we && (addr == ADDR_TIME);
  assign feed_o      = we && (addr == ADDR_FEED) && wdata[0];
  assign unused_wdata = ^wdata[DW-1:7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      timing_q <= '0;
    end else begin
      if (ctrl_wr_o) begin
        ctrl_q <= ctrl_t'(wdata[3:0]);
      end
      if (timing_wr_o) begin
        timing_q.sel   <= wdata[6:4];
        timing_q.ratio <= wdata[1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CTRL: rdata[3:0] = ctrl_q;
      ADDR_TIME: begin
        rdata[6:4] = timing_q.sel;
        rdata[1:0] = timing_q.ratio;
      end
      default:   rdata = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign timing_o = timing_q;
endmodule

// File: rtl/wwdt_window.sv
module wwdt_window
  import wwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slow,
  input  logic             act_rst,
  input  logic [CNT_W-1:0] short_t,
  input  logic [CNT_W-1:0] long_t,
  input  logic             tick,
  input  logic             feed,
  input  logic             cfg_restart,
  output logic [CNT_W-1:0] tick_cnt_o,
  output logic             early_o,
  output logic             late_o,
  output logic             fault_o,
  output logic             rst_pulse_o,
  output logic             irq_pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             restart;

  // early: window mode, feed before the short limit has fully passed
  assign early_o = run && !slow && feed && (cnt_q < short_t);
  // late: last tick of the long limit, not rescued by a feed or config write
  assign late_o  = run && tick && (cnt_q == long_t - 1'b1) && !feed && !cfg_restart;
  assign fault_o = early_o || late_o;
  assign restart = !run || feed || cfg_restart || fault_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      irq_pulse_o <= 1'b0;
      rst_pulse_o <= 1'b0;
    end else begin
      irq_pulse_o <= fault_o;
      rst_pulse_o <= fault_o && act_rst;
      if (restart) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tick_cnt_o = cnt_q;
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
  import wwdt_pkg::*;
#(
  parameter int CLK_PER_TICK = 55000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wdog_rst_o,
  output logic       wdog_irq_o
);
  ctrl_t            ctrl;
  timing_t          timing;
  logic             ctrl_wr, timing_wr, feed;
  logic             run, slow, cfg_wr, pre_clear, tick;
  logic [CNT_W-1:0] short_t, long_t, tick_cnt;
  logic             early_evt, late_evt, fault_evt;

  wwdt_regs #(.DW(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ctrl_o(ctrl), .timing_o(timing),
    .ctrl_wr_o(ctrl_wr), .timing_wr_o(timing_wr), .feed_o(feed)
  );

  assign run       = (ctrl.run == RUN_ON);
  assign slow      = ctrl.slow;
  assign cfg_wr    = ctrl_wr || timing_wr;
  assign short_t   = short_ticks(timing.sel);
  assign long_t    = long_ticks(timing.sel, timing.ratio);
  assign pre_clear = feed || cfg_wr;

  wwdt_prescaler #(.DIV(CLK_PER_TICK)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(pre_clear), .tick(tick)
  );

  wwdt_window u_win (
    .clk(clk), .rst_n(rst_n), .run(run), .slow(slow), .act_rst(ctrl.act_rst),
    .short_t(short_t), .long_t(long_t), .tick(tick), .feed(feed),
    .cfg_restart(cfg_wr), .tick_cnt_o(tick_cnt), .early_o(early_evt),
    .late_o(late_evt), .fault_o(fault_evt), .rst_pulse_o(wdog_rst_o),
    .irq_pulse_o(wdog_irq_o)
  );
endmodule

// File: rtl/wwdt_checker.sv
module wwdt_checker
  import wwdt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             slow,
  input logic             feed,
  input logic             cfg_wr,
  input logic [CNT_W-1:0] tick_cnt,
  input logic [CNT_W-1:0] short_t,
  input logic [CNT_W-1:0] long_t,
  input logic [1:0]       bus_addr,
  input logic [7:0]       bus_rdata,
  input logic             wdog_rst_o,
  input logic             wdog_irq_o
);
  assert_rst_with_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> wdog_irq_o);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !wdog_irq_o);

  assert_early_feed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !slow && feed && tick_cnt < short_t) |=> wdog_irq_o);

  assert_slow_feed_safe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && slow && feed) |=> !wdog_irq_o);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> tick_cnt < long_t);

  assert_feed_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_FEED) |-> bus_rdata == 8'h00);

  assert_cfg_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> tick_cnt == '0);
endmodule

bind wwdt_core wwdt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .slow(slow), .feed(feed),
  .cfg_wr(cfg_wr), .tick_cnt(tick_cnt), .short_t(short_t), .long_t(long_t),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .wdog_rst_o(wdog_rst_o),
  .wdog_irq_o(wdog_irq_o)
);

// File: tb/wwdt_core_tb_top.sv
module wwdt_core_tb_top;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wdog_rst_o, wdog_irq_o;

  always #10 clk = ~clk;

  wwdt_core #(.CLK_PER_TICK(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdog_rst_o(wdog_rst_o), .wdog_irq_o(wdog_irq_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {int at; logic rst; string tag;} exp_t;
  exp_t  q[$];
  int    n_chk = 0, n_fail = 0, n_unexp = 0, last_edge = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_fault(input int at, input logic rst, input string tag);
    exp_t e;
    e.at = at; e.rst = rst; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare observed fault pulses against the queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (q.size() > 0 && q[0].at < cyc) begin
        check(1'b0, q[0].tag, 0, q[0].at);
        void'(q.pop_front());
      end
      if (wdog_irq_o || wdog_rst_o) begin
        if (q.size() > 0 && q[0].at == cyc) begin
          check(wdog_irq_o && (wdog_rst_o == q[0].rst), q[0].tag,
                int'({wdog_irq_o, wdog_rst_o}), int'({1'b1, q[0].rst}));
          void'(q.pop_front());
        end else begin
          n_unexp++;
          check(1'b0, cur_tag, cyc, -1);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = 8'h00;
    last_edge = cyc;
  endtask

  task automatic wr_at(input int target, input logic [1:0] a, input logic [7:0] d);
    while (cyc < target - 1) @(negedge clk);
    wr(a, d);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int n, e, u;
    repeat (3) @(negedge clk);
    check(wdog_irq_o == 1'b0 && wdog_rst_o == 1'b0, "R1", int'({wdog_irq_o, wdog_rst_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d); check(d == 8'h00, "R1", d, 0);
    rd(2'd1, d); check(d == 8'h00, "R1", d, 0);

    // R2 register layout
    cur_tag = "R2";
    wr(2'd1, 8'hFF); rd(2'd1, d); check(d == 8'h73, "R2", d, 8'h73);
    wr(2'd0, 8'hF6); rd(2'd0, d); check(d == 8'h06, "R2", d, 8'h06);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h10); rd(2'd1, d); check(d == 8'h10, "R2", d, 8'h10);
    // R3 feed reads zero
    wr(2'd2, 8'h01); rd(2'd2, d); check(d == 8'h00, "R3", d, 0);

    // R5/R8/R10: short=2 ticks, long=4 ticks (16 clocks), reset action
    cur_tag = "R5";
    wr(2'd0, 8'h09); n = last_edge;
    expect_fault(n + 16, 1'b1, "R5");
    expect_fault(n + 32, 1'b1, "R10");
    wr_at(n + 36, 2'd0, 8'h08);
    repeat (30) @(negedge clk);

    // R6 window: early, accepted, boundary early, then timeout (irq only)
    cur_tag = "R6";
    wr(2'd0, 8'h01); n = last_edge;
    wr_at(n + 5, 2'd2, 8'h01); e = last_edge; expect_fault(e, 1'b0, "R6");
    wr_at(e + 9, 2'd2, 8'h01); e = last_edge;
    wr_at(e + 8, 2'd2, 8'h01); e = last_edge; expect_fault(e, 1'b0, "R6");
    expect_fault(e + 16, 1'b0, "R8");
    wr_at(e + 20, 2'd0, 8'h00);
    repeat (10) @(negedge clk);

    // R7 slow mode: quick feeds are fine
    cur_tag = "R7";
    wr(2'd0, 8'h05); n = last_edge;
    wr_at(n + 1, 2'd2, 8'h01); e = last_edge;
    wr_at(e + 3, 2'd2, 8'h01); e = last_edge;
    expect_fault(e + 16, 1'b0, "R7");
    wr_at(e + 20, 2'd0, 8'h00);
    repeat (10) @(negedge clk);

    // R11 timing rewrite restarts the count
    cur_tag = "R11";
    wr(2'd0, 8'h01); n = last_edge;
    wr_at(n + 12, 2'd1, 8'h10); e = last_edge;
    expect_fault(e + 16, 1'b0, "R11");
    wr_at(e + 20, 2'd0, 8'h00);
    repeat (10) @(negedge clk);

    // R12 feed on the expiry edge wins
    cur_tag = "R12";
    wr(2'd0, 8'h01); n = last_edge;
    wr_at(n + 16, 2'd2, 8'h01); e = last_edge;
    expect_fault(e + 16, 1'b0, "R12");
    wr_at(e + 20, 2'd0, 8'h00);
    repeat (10) @(negedge clk);

    // R4 select 2, ratio 1: short=4 ticks (16 clocks), long=16 ticks (64 clocks)
    cur_tag = "R4";
    wr(2'd1, 8'h21);
    wr(2'd0, 8'h09); n = last_edge;
    expect_fault(n + 64, 1'b1, "R4");
    wr_at(n + 64 + 17, 2'd2, 8'h01); e = last_edge;
    wr_at(e + 16, 2'd2, 8'h01); e = last_edge; expect_fault(e, 1'b1, "R4");
    wr_at(e + 20, 2'd0, 8'h00);
    repeat (10) @(negedge clk);

    // R5 largest ratio: select 0, ratio 3 -> 16 ticks
    cur_tag = "R5";
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h01); n = last_edge;
    expect_fault(n + 64, 1'b0, "R5");
    wr_at(n + 68, 2'd0, 8'h00);
    wr(2'd1, 8'h10);

    // R9 non-run codes and elapsed time discarded
    cur_tag = "R9";
    u = n_unexp;
    wr(2'd0, 8'h02); repeat (40) @(negedge clk); wr(2'd2, 8'h01);
    wr(2'd0, 8'h03); repeat (40) @(negedge clk); wr(2'd2, 8'h01);
    rd(2'd0, d); check(d == 8'h03, "R9", d, 8'h03);
    check(n_unexp == u, "R9", n_unexp, u);
    wr(2'd0, 8'h01); n = last_edge;
    wr_at(n + 10, 2'd0, 8'h00);
    wr_at(n + 13, 2'd0, 8'h01); e = last_edge;
    expect_fault(e + 16, 1'b0, "R9");
    wr_at(e + 20, 2'd0, 8'h00);
    repeat (10) @(negedge clk);

    check(q.size() == 0, "R5", q.size(), 0);
    finish_run();
  end
endmodule